// File: doc/BRIEF.md
# Phased Read-Modify-Write Register File

This block is the data store of a small 8-bit controller core. Each instruction cycle is four clocks long. In that time the block reads one addressed byte, changes it in a small ALU (pass, increment, decrement or clear) and can write the new value back to the same byte. The storage is a plain single-port synchronous array. Because the read and the write fall in different clocks of the same instruction cycle, the array never needs a second port. It still completes one read-modify-write per instruction cycle, with no stalls between instructions.

A sequencer steps through the phases Q1, Q2, Q3 and Q4 without stopping. The core offers an instruction by raising a start strobe during Q1, together with the address, the operation code and a write-back enable. The block captures these at the clock edge that ends Q1 and holds them for the rest of the cycle. The byte that was read, the ALU result and a zero flag appear on the outputs for the core to use. A one-hot phase output shows which phase is current.

Top module: `phased_rmw_file`

## Requirements
- R1: After reset the phase output reads Q1, and on every clock it then moves to the next phase in the repeating order Q1, Q2, Q3, Q4. The output is one-hot, with bit 0 for Q1 and bit 3 for Q4.
- R2: The start strobe, address, operation code and write-back enable are sampled only at the clock edge that ends Q1. Values on these inputs during Q2, Q3 or Q4 have no effect.
- R3: The addressed byte is read at the edge that ends Q2. The operand, result and zero flag outputs take their new values at the edge that ends Q3, so they are visible from Q4 of the same instruction cycle.
- R4: The operation codes are 0 for pass, 1 for increment, 2 for decrement and 3 for clear (the result is 0). Arithmetic wraps modulo 256, so 0xFF plus one gives 0x00 and 0x00 minus one gives 0xFF.
- R5: When write-back is enabled, the result is written to the latched address at the edge that ends Q4. An instruction in the very next cycle reads the updated value. Back-to-back instructions each complete in one four-clock cycle.
- R6: When write-back enable is low, the array is left unchanged, but the operand, result and zero flag are still produced.
- R7: The zero flag is 1 exactly when the 8-bit result is 0x00.
- R8: A synchronous reset returns the sequencer to Q1 and clears the operand, result and zero flag. It leaves the array contents unchanged.
- R9: If the start strobe is low in Q1, that instruction cycle performs no read and no write, and the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Instruction strobe, sampled in Q1 |
| locAddr | input | ADDR_W (10) | Address of the byte to operate on |
| opSel | input | 2 | Operation code: 0 pass, 1 increment, 2 decrement, 3 clear |
| wbEn | input | 1 | Write the result back to the byte in Q4 |
| operandOut | output | DATA_W (8) | Byte read in Q2 |
| resultOut | output | DATA_W (8) | ALU result |
| zeroFlag | output | 1 | 1 when the result is zero |
| phaseOh | output | 4 | One-hot phase indicator, bit 0 = Q1 |

## Verification
Assertions check the following on every cycle:
- the phase rotation;
- that the ALU step always follows a read, and the write always follows the ALU step;
- that the latched address does not move between the read and the write;
- that the array is never read and written in the same clock;
- that the outputs hold when no ALU step occurs;
- that the zero flag matches the result, including the increment wrap.

Some behaviours can only be shown by the bench scenarios, through a reference model that stores every byte:
- that a written value is really read back in the next instruction cycle;
- that suppressed write-backs leave the stored data unchanged;
- that inputs outside Q1 are ignored;
- that a reset in mid-run keeps the array contents.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

  localparam int NUM_PHASES = 4;
  localparam int PHASE_W    = $clog2(NUM_PHASES);

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_INC  = 2'd1,
    OP_DEC  = 2'd2,
    OP_CLR  = 2'd3
  } aluOp_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchEn;  // Q1: capture the instruction
    logic rdEn;     // Q2: read the array
    logic aluEn;    // Q3: register the ALU result
    logic wrEn;     // Q4: write back
  } strobes_t;

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  startValid,
  input  logic                  wbEn,
  output strobes_t              strb,
  output logic [NUM_PHASES-1:0] phaseOh
);

  logic [PHASE_W-1:0] phaseIdx;
  logic               active;
  logic               wbHeld;
  logic               inQ1;

  assign inQ1 = (phaseIdx == PHASE_W'(0));

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseIdx <= '0;
      active   <= 1'b0;
      wbHeld   <= 1'b0;
    end else begin
      phaseIdx <= phaseIdx + PHASE_W'(1);
      if (inQ1) begin
        active <= startValid;
        wbHeld <= startValid & wbEn;
      end
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : gPhase
    assign phaseOh[g] = (phaseIdx == PHASE_W'(g));
  end

  always_comb begin
    strb         = '0;
    strb.latchEn = inQ1 & startValid;
    strb.rdEn    = (phaseIdx == PHASE_W'(1)) & active;
    strb.aluEn   = (phaseIdx == PHASE_W'(2)) & active;
    strb.wrEn    = (phaseIdx == PHASE_W'(3)) & active & wbHeld;
  end

  // R1: the phase rotates one position each clock
  assert_phase_rotate_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phaseOh == {$past(phaseOh[NUM_PHASES-2:0]), $past(phaseOh[NUM_PHASES-1])});

  // R2: the instruction state only changes at the end of Q1
  assert_hold_outside_q1_R2: assert property (@(posedge clk) disable iff (rst)
    !phaseOh[0] |=> $stable(active) && $stable(wbHeld));

endmodule

// File: rtl/rmw_store.sv
module rmw_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] cells [DEPTH];

  // array contents survive reset
  always_ff @(posedge clk) begin
    if (wrEn) cells[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdData <= '0;
    else if (rdEn) rdData <= cells[addr];
  end

  // R5: one port only, so a read and a write never share a clock
  assert_single_port_R5: assert property (@(posedge clk) disable iff (rst)
    !(rdEn && wrEn));

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluOp_t            op,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (op)
      OP_PASS: result = operand;
      OP_INC:  result = operand + DATA_W'(1);
      OP_DEC:  result = operand - DATA_W'(1);
      OP_CLR:  result = '0;
      default: result = operand;
    endcase
  end

endmodule

// File: rtl/rmw_datapath.sv
module rmw_datapath
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [1:0]        opSel,
  output logic [DATA_W-1:0] operandOut,
  output logic [DATA_W-1:0] resultOut,
  output logic              zeroFlag
);

  logic [ADDR_W-1:0] addrQ;
  aluOp_t            opQ;
  logic [DATA_W-1:0] rdData;
  logic [DATA_W-1:0] aluOut;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      opQ   <= OP_PASS;
    end else if (strb.latchEn) begin
      addrQ <= locAddr;
      opQ   <= aluOp_t'(opSel);
    end
  end

  rmw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uStore (
    .clk    (clk),
    .rst    (rst),
    .rdEn   (strb.rdEn),
    .wrEn   (strb.wrEn),
    .addr   (addrQ),
    .wrData (resultOut),
    .rdData (rdData)
  );

  rmw_alu #(.DATA_W(DATA_W)) uAlu (
    .op      (opQ),
    .operand (rdData),
    .result  (aluOut)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operandOut <= '0;
      resultOut  <= '0;
      zeroFlag   <= 1'b0;
    end else if (strb.aluEn) begin
      operandOut <= rdData;
      resultOut  <= aluOut;
      zeroFlag   <= (aluOut == '0);
    end
  end

  // R2: the latched address stays fixed from the read until the write
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.aluEn || strb.wrEn) |-> $stable(addrQ));

  // R3: the ALU step always comes one clock after a read
  assert_alu_after_read_R3: assert property (@(posedge clk) disable iff (rst)
    strb.aluEn |-> $past(strb.rdEn));

  // R5: a write-back always comes one clock after the ALU step
  assert_write_after_alu_R5: assert property (@(posedge clk) disable iff (rst)
    strb.wrEn |-> $past(strb.aluEn));

  // R4: increment of 0xFF wraps to zero and raises the flag
  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.aluEn && opQ == OP_INC && rdData == '1) |=> (resultOut == '0) && zeroFlag);

  // R7: the zero flag agrees with the registered result
  assert_zero_match_R7: assert property (@(posedge clk) disable iff (rst)
    strb.aluEn |=> zeroFlag == (resultOut == '0));

  // R9: without an ALU step the outputs hold
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.aluEn |=> $stable(resultOut) && $stable(operandOut) && $stable(zeroFlag));

endmodule

// File: rtl/phased_rmw_file.sv
module phased_rmw_file #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic [1:0]        opSel,
  input  logic              wbEn,
  output logic [DATA_W-1:0] operandOut,
  output logic [DATA_W-1:0] resultOut,
  output logic              zeroFlag,
  output logic [3:0]        phaseOh
);

  rmw_pkg::strobes_t strb;

  rmw_ctrl uCtrl (
    .clk        (clk),
    .rst        (rst),
    .startValid (startValid),
    .wbEn       (wbEn),
    .strb       (strb),
    .phaseOh    (phaseOh)
  );

  rmw_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) uDp (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .locAddr    (locAddr),
    .opSel      (opSel),
    .operandOut (operandOut),
    .resultOut  (resultOut),
    .zeroFlag   (zeroFlag)
  );

endmodule

// File: tb/sim_phased_rmw_file.sv
module sim_phased_rmw_file;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              startValid = 1'b0;
  logic [ADDR_W-1:0] locAddr = '0;
  logic [1:0]        opSel = 2'd0;
  logic              wbEn = 1'b0;
  logic [DATA_W-1:0] operandOut, resultOut;
  logic              zeroFlag;
  logic [3:0]        phaseOh;

  always #4 clk = ~clk;  // 125 MHz

  phased_rmw_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .startValid(startValid), .locAddr(locAddr),
    .opSel(opSel), .wbEn(wbEn), .operandOut(operandOut),
    .resultOut(resultOut), .zeroFlag(zeroFlag), .phaseOh(phaseOh)
  );

  int checks = 0;
  int fails  = 0;
  bit armed  = 0;
  string curReq = "R8";

  // behavioural reference model
  logic [7:0] refMem [int];
  int         mPhase = 0;
  bit         mActive = 0, mWb = 0;
  int         mAddr = 0, mOp = 0;
  logic [7:0] mRd = 0, mOperand = 0, mResult = 0;
  bit         mZero = 0;

  function automatic logic [7:0] refAlu(int op, logic [7:0] v);
    case (op)
      0: return v;
      1: return v + 8'd1;
      2: return v - 8'd1;
      default: return 8'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mPhase = 0; mActive = 0; mWb = 0; mAddr = 0; mOp = 0;
      mRd = 0; mOperand = 0; mResult = 0; mZero = 0;
    end else begin
      case (mPhase)
        0: begin
          mActive = startValid;
          mWb     = startValid && wbEn;
          if (startValid) begin mAddr = int'(locAddr); mOp = int'(opSel); end
        end
        1: if (mActive) mRd = refMem.exists(mAddr) ? refMem[mAddr] : 8'h00;
        2: if (mActive) begin
          mOperand = mRd;
          mResult  = refAlu(mOp, mRd);
          mZero    = (mResult == 8'h00);
        end
        default: if (mActive && mWb) refMem[mAddr] = mResult;
      endcase
      mPhase = (mPhase + 1) % 4;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (phaseOh !== (4'b0001 << mPhase)) begin
        fails++;
        $display("FAIL %s phase: actual %b expected %b", curReq, phaseOh, 4'b0001 << mPhase);
      end
      checks++;
      if (operandOut !== mOperand || resultOut !== mResult || zeroFlag !== mZero) begin
        fails++;
        $display("FAIL %s outputs: actual op=%h res=%h z=%b expected op=%h res=%h z=%b",
                 curReq, operandOut, resultOut, zeroFlag, mOperand, mResult, mZero);
      end
    end
  end

  // offer one instruction in Q1, then put noise on the inputs (R2)
  task automatic issue(input bit sv, input int a, input int op, input bit wb);
    @(negedge clk);
    while (phaseOh !== 4'b0001) @(negedge clk);
    startValid = sv; locAddr = ADDR_W'(a); opSel = 2'(op); wbEn = wb;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      startValid = 1'($urandom_range(0, 1));
      locAddr    = ADDR_W'($urandom_range(0, DEPTH - 1));
      opSel      = 2'($urandom_range(0, 3));
      wbEn       = 1'($urandom_range(0, 1));
    end
  endtask

  task automatic pulseReset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // explicit output check at the end of an instruction cycle (Q4 visible)
  task automatic expectOut(input string tag, input logic [7:0] res, input bit z);
    checks++;
    if (resultOut !== res || zeroFlag !== z) begin
      fails++;
      $display("FAIL %s: actual res=%h z=%b expected res=%h z=%b", tag, resultOut, zeroFlag, res, z);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    armed = 1;
    curReq = "R8";
    repeat (2) @(negedge clk);
    rst = 1'b0;

    curReq = "R4";   // clear some locations
    foreach (refMem[i]) refMem.delete(i);
    for (int a = 0; a < 4; a++) issue(1, a, 3, 1);
    issue(1, 9, 3, 1);
    issue(1, DEPTH - 1, 3, 1);
    expectOut("R4 clear", 8'h00, 1'b1);

    curReq = "R5";   // back-to-back increments of one location
    for (int k = 0; k < 3; k++) issue(1, 1, 1, 1);
    expectOut("R5 inc x3", 8'h03, 1'b0);
    issue(1, 2, 1, 1); issue(1, 3, 2, 1);
    expectOut("R4 dec wrap", 8'hFF, 1'b0);

    curReq = "R7";   // wrap to zero
    issue(1, 9, 2, 1); issue(1, 9, 1, 1);
    expectOut("R7 zero", 8'h00, 1'b1);

    curReq = "R6";   // no write-back
    issue(1, 1, 1, 0); issue(1, 1, 1, 0);
    expectOut("R6 no write", 8'h04, 1'b0);
    issue(1, 1, 0, 1);
    expectOut("R6 kept", 8'h03, 1'b0);

    curReq = "R9";   // idle instruction cycles
    issue(0, 1, 3, 1); issue(0, 2, 3, 1);
    expectOut("R9 hold", 8'h03, 1'b0);
    issue(1, 1, 0, 0);
    expectOut("R9 untouched", 8'h03, 1'b0);

    curReq = "R8";   // reset keeps the array
    pulseReset();
    expectOut("R8 cleared", 8'h00, 1'b0);
    issue(1, 1, 0, 0);
    expectOut("R8 array kept", 8'h03, 1'b0);

    curReq = "R1";   // top address
    issue(1, DEPTH - 1, 2, 1); issue(1, DEPTH - 1, 0, 0);
    expectOut("R1 top addr", 8'hFF, 1'b0);

    curReq = "R2";   // mixed random traffic
    for (int n = 0; n < 40; n++)
      issue(1'($urandom_range(0, 3) != 0), $urandom_range(0, 3),
            $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    curReq = "R3";
    for (int n = 0; n < 20; n++) issue(1, n % 4, n % 3, 1);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule